// File: doc/BRIEF.md
# Register File with Same-Cycle Write Bypass

This block holds a bank of general-purpose registers for a pipelined processor core. It has two read ports that answer combinationally from the register number presented, and one write port that commits data into the array on the rising clock edge. All storage and all ports work on that single edge. Nothing in the block is triggered by the falling edge.

A decode stage often reads a register in the same cycle that write-back is storing a new value into that register. The block handles this case itself. Each read port compares its address with the active write. On a match, the port returns the incoming write data in place of the stored value. The decode stage therefore always sees the newest value, and the pipeline needs no separate forwarding path from write-back to decode.

Register number zero is a constant zero. Reads of it return zero, writes to it are discarded, and it never takes part in the bypass. The address width, the data width and the presence of the constant-zero register are parameters.

Top module: `rfb_regfile`

## Requirements
- R1: Both read ports are combinational. A change of `rd_addr_a` or `rd_addr_b` shows up on the matching data output within the same cycle, with no clock edge needed.
- R2: When `wr_en` is high and `wr_addr` is not zero, `wr_data` is stored into register `wr_addr` at the rising clock edge. After that edge, a read of that register returns the stored value until the register is written again.
- R3: A read of register 0 returns all zeros on either port.
- R4: A write to register 0 changes nothing. Register 0 still reads as zero both in the cycle of the write and after it.
- R5: When `wr_en` is high, `wr_addr` equals a port's read address, and that address is not zero, the port returns `wr_data` in the same cycle, before the edge that stores it.
- R6: When `wr_en` is low, a read whose address equals `wr_addr` returns the stored value and ignores `wr_data`. No register is written at the following edge.
- R7: The two read ports compare against the write independently. One port can receive bypassed data while the other port, reading a different register, returns its stored value.
- R8: When a port's read address differs from `wr_addr`, that port's output does not change when `wr_data` or `wr_en` changes.
- R9: When both ports read the register being written, both ports return `wr_data` in that cycle.
- R10: When one register is written on consecutive cycles, a port reading that register returns the write data of the current cycle in each of those cycles. After the writes stop, it returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the array is written on the rising edge |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 5 | Register number to be written |
| wr_data | input | 32 | Data to be written |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Read data of port A, with bypass applied |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Read data of port B, with bypass applied |

## Verification
The key collision is a read and a write of the same register in the same cycle. The bench forces this by presenting the write and the matching read address together in the half cycle before a rising edge. It first samples the read data before that edge, where the new data must already appear, and then samples again after the edge, where the stored value must match. The bench compares every read with a model array that it updates only at rising edges. It repeats the collision with the enable low, with the target set to register zero, with only one port matching, with both ports matching, and with several writes to one register in a row.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

   localparam int unsigned RFB_AW_DEF   = 5;
   localparam int unsigned RFB_DW_DEF   = 32;
   localparam int unsigned RFB_RD_PORTS = 2;

   // true when an active write targets the register a port is reading,
   // excluding the constant-zero register when it exists
   function automatic logic rfb_hit(input logic        en,
                                    input int unsigned wa,
                                    input int unsigned ra,
                                    input logic        zero_reg);
      return en && (wa == ra) && !(zero_reg && (ra == 0));
   endfunction

endpackage

// File: rtl/rfb_wdec.sv
module rfb_wdec #(
   parameter int unsigned AW       = 5,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned NREG    = 1 << AW
) (
   input  logic            clk,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   output logic [NREG-1:0] row_we
);

   for (genvar r = 0; r < NREG; r++) begin : g_row
      if (ZERO_REG && (r == 0)) begin : g_const
         assign row_we[r] = 1'b0;
      end else begin : g_cmp
         assign row_we[r] = wr_en && (wr_addr == AW'(r));
      end
   end

   AST_ONE_ROW_AT_MOST: assert property (@(posedge clk) $onehot0(row_we)); // R2

   AST_ROW_FOLLOWS_WRITE: assert property (@(posedge clk)
      (wr_en && !(ZERO_REG && wr_addr == '0)) |-> row_we[wr_addr]); // R2

   AST_NO_ROW_WITHOUT_EN: assert property (@(posedge clk)
      !wr_en |-> (row_we == '0)); // R6

   if (ZERO_REG) begin : g_zero_chk
      AST_ZERO_ROW_BLOCKED: assert property (@(posedge clk)
         (wr_en && wr_addr == '0) |-> (row_we == '0)); // R4
   end

endmodule

// File: rtl/rfb_store.sv
module rfb_store #(
   parameter int unsigned AW       = 5,
   parameter int unsigned DW       = 32,
   parameter int unsigned NRD      = 2,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned NREG    = 1 << AW
) (
   input  logic            clk,
   input  logic [NREG-1:0] row_we,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [AW-1:0]   rd_addr [NRD],
   output logic [DW-1:0]   stored  [NRD]
);

   logic [DW-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      for (int r = 0; r < NREG; r++) begin
         if (row_we[r]) mem[r] <= wr_data;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_port
      if (ZERO_REG) begin : g_zmux
         assign stored[p] = (rd_addr[p] == '0) ? '0 : mem[rd_addr[p]];

         AST_ZERO_STORED: assert property (@(posedge clk)
            (rd_addr[p] == '0) |-> (stored[p] == '0)); // R3
      end else begin : g_plain
         assign stored[p] = mem[rd_addr[p]];
      end

      AST_READBACK_AFTER_EDGE: assert property (@(posedge clk)
         (|row_we) |=> ((rd_addr[p] != $past(wr_addr)) ||
                        (stored[p] == $past(wr_data)))); // R2
   end

endmodule

// File: rtl/rfb_bypass.sv
module rfb_bypass #(
   parameter int unsigned AW       = 5,
   parameter int unsigned DW       = 32,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] stored,
   output logic [DW-1:0] rd_data
);

   import rfb_pkg::*;

   logic hit;

   always_comb begin
      hit     = rfb_hit(wr_en, int'(wr_addr), int'(rd_addr), ZERO_REG);
      rd_data = hit ? wr_data : stored;
   end

   AST_BYPASS_NEW_VALUE: assert property (@(posedge clk)
      (wr_en && wr_addr == rd_addr && !(ZERO_REG && rd_addr == '0))
         |-> (rd_data == wr_data)); // R5

   AST_DISABLED_NO_BYPASS: assert property (@(posedge clk)
      !wr_en |-> (rd_data == stored)); // R6

   AST_MISMATCH_STORED: assert property (@(posedge clk)
      (wr_addr != rd_addr) |-> (rd_data == stored)); // R8

   if (ZERO_REG) begin : g_zero_chk
      AST_ZERO_NEVER_BYPASSED: assert property (@(posedge clk)
         (rd_addr == '0) |-> (rd_data == '0)); // R4
   end

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile #(
   parameter int unsigned AW       = rfb_pkg::RFB_AW_DEF,
   parameter int unsigned DW       = rfb_pkg::RFB_DW_DEF,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr_a,
   output logic [DW-1:0] rd_data_a,
   input  logic [AW-1:0] rd_addr_b,
   output logic [DW-1:0] rd_data_b
);

   localparam int unsigned NRD  = rfb_pkg::RFB_RD_PORTS;
   localparam int unsigned NREG = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("rfb_regfile: AW must lie in 1..10");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rfb_regfile: DW must be at least 1");
   end
   if (NRD != 2) begin : g_bad_nrd
      $error("rfb_regfile: top exposes exactly two read ports");
   end

   logic [NREG-1:0] row_we;
   logic [AW-1:0]   rd_addr [NRD];
   logic [DW-1:0]   stored  [NRD];
   logic [DW-1:0]   rd_data [NRD];

   assign rd_addr[0] = rd_addr_a;
   assign rd_addr[1] = rd_addr_b;
   assign rd_data_a  = rd_data[0];
   assign rd_data_b  = rd_data[1];

   rfb_wdec #(.AW(AW), .ZERO_REG(ZERO_REG)) u_wdec (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .row_we  (row_we)
   );

   rfb_store #(.AW(AW), .DW(DW), .NRD(NRD), .ZERO_REG(ZERO_REG)) u_store (
      .clk     (clk),
      .row_we  (row_we),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .stored  (stored)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      rfb_bypass #(.AW(AW), .DW(DW), .ZERO_REG(ZERO_REG)) u_byp (
         .clk     (clk),
         .wr_en   (wr_en),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .rd_addr (rd_addr[p]),
         .stored  (stored[p]),
         .rd_data (rd_data[p])
      );
   end

   AST_PORTS_AGREE: assert property (@(posedge clk)
      (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b)); // R9

   AST_LATEST_WRITE_WINS: assert property (@(posedge clk)
      (wr_en && wr_addr != '0) |=>
         ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data)) ||
          (wr_en && wr_addr == rd_addr_a))); // R10

endmodule

// File: tb/sim_rfb_regfile.sv
module sim_rfb_regfile;

   logic        clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr_a = '0;
   logic [4:0]  rd_addr_b = '0;
   logic [31:0] rd_data_a;
   logic [31:0] rd_data_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] model [32];

   always #10 clk = ~clk;

   rfb_regfile u0 (
      .clk       (clk),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr_a (rd_addr_a),
      .rd_data_a (rd_data_a),
      .rd_addr_b (rd_addr_b),
      .rd_data_b (rd_data_b)
   );

   function automatic logic [31:0] pat(input int i);
      return 32'hC3A50000 ^ (32'(i) * 32'h01030507);
   endfunction

   // expected read value from the requirements and the model array
   function automatic logic [31:0] expect_rd(input logic [4:0] ra);
      if (ra == 0) return '0;
      if (wr_en && wr_addr == ra) return wr_data;
      return model[ra];
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // apply inputs after a falling edge, leave time to settle
   task automatic apply(input logic en, input logic [4:0] wa,
                        input logic [31:0] wd, input logic [4:0] ra,
                        input logic [4:0] rb);
      @(negedge clk);
      wr_en = en; wr_addr = wa; wr_data = wd;
      rd_addr_a = ra; rd_addr_b = rb;
      #2;
   endtask

   // cross the rising edge and update the model
   task automatic commit();
      @(posedge clk);
      if (wr_en && wr_addr != 0) model[wr_addr] = wr_data;
   endtask

   task automatic t_fill();
      for (int i = 1; i < 32; i++) begin
         apply(1'b1, 5'(i), pat(i), 5'd0, 5'd0);
         commit();
      end
      apply(1'b0, 5'd0, '0, 5'd1, 5'd31);
      check("R2 port A reg1", rd_data_a, pat(1));
      check("R2 port B reg31", rd_data_b, pat(31));
      for (int i = 2; i < 31; i += 7) begin
         #1 rd_addr_a = 5'(i); rd_addr_b = 5'(i + 1);
         #1;
         check("R1 port A address change", rd_data_a, pat(i));
         check("R1 port B address change", rd_data_b, pat(i + 1));
      end
      commit();
   endtask

   task automatic t_zero();
      apply(1'b0, 5'd0, '0, 5'd0, 5'd0);
      check("R3 port A reg0", rd_data_a, 32'h0);
      check("R3 port B reg0", rd_data_b, 32'h0);
      commit();
      apply(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
      check("R4 reg0 same cycle A", rd_data_a, 32'h0);
      check("R4 reg0 same cycle B", rd_data_b, 32'h0);
      commit();
      apply(1'b0, 5'd0, '0, 5'd0, 5'd1);
      check("R4 reg0 after write", rd_data_a, 32'h0);
      check("R4 reg1 untouched", rd_data_b, model[1]);
      commit();
   endtask

   task automatic t_bypass_one_port();
      apply(1'b1, 5'd5, 32'h1234_5678, 5'd5, 5'd6);
      check("R5 bypass port A", rd_data_a, 32'h1234_5678);
      check("R7 port B stored", rd_data_b, expect_rd(5'd6));
      commit();
      apply(1'b1, 5'd6, 32'h0BAD_F00D, 5'd5, 5'd6);
      check("R7 port A stored", rd_data_a, 32'h1234_5678);
      check("R5 bypass port B", rd_data_b, 32'h0BAD_F00D);
      commit();
      apply(1'b0, 5'd0, '0, 5'd5, 5'd6);
      check("R2 reg5 after edge", rd_data_a, expect_rd(5'd5));
      check("R2 reg6 after edge", rd_data_b, expect_rd(5'd6));
      commit();
   endtask

   task automatic t_disabled();
      logic [31:0] old8;
      old8 = model[8];
      apply(1'b0, 5'd8, 32'hDEAD_BEEF, 5'd8, 5'd8);
      check("R6 no bypass when disabled A", rd_data_a, old8);
      check("R6 no bypass when disabled B", rd_data_b, old8);
      commit();
      apply(1'b0, 5'd0, '0, 5'd8, 5'd9);
      check("R6 reg8 not written", rd_data_a, old8);
      commit();
   endtask

   task automatic t_unaffected();
      logic [31:0] va, vb;
      va = model[9]; vb = model[10];
      for (int k = 0; k < 4; k++) begin
         apply(k[0], 5'd11, pat(100 + k), 5'd9, 5'd10);
         check("R8 port A unaffected", rd_data_a, va);
         check("R8 port B unaffected", rd_data_b, vb);
         #1 wr_data = ~wr_data; wr_en = ~wr_en;
         #1;
         check("R8 port A after toggle", rd_data_a, va);
         check("R8 port B after toggle", rd_data_b, vb);
         wr_en = k[0]; wr_data = pat(100 + k);
         commit();
      end
   endtask

   task automatic t_both();
      apply(1'b1, 5'd12, 32'hA0B1_C2D3, 5'd12, 5'd12);
      check("R9 both bypass A", rd_data_a, 32'hA0B1_C2D3);
      check("R9 both bypass B", rd_data_b, 32'hA0B1_C2D3);
      commit();
      apply(1'b0, 5'd0, '0, 5'd12, 5'd12);
      check("R9 stored A", rd_data_a, 32'hA0B1_C2D3);
      check("R9 stored B", rd_data_b, 32'hA0B1_C2D3);
      commit();
   endtask

   task automatic t_back_to_back();
      for (int k = 0; k < 3; k++) begin
         apply(1'b1, 5'd7, pat(200 + k), 5'd7, 5'd3);
         check("R10 current write visible", rd_data_a, pat(200 + k));
         check("R10 other port stored", rd_data_b, expect_rd(5'd3));
         commit();
      end
      apply(1'b0, 5'd7, 32'h5555_AAAA, 5'd7, 5'd7);
      check("R10 last value kept A", rd_data_a, pat(202));
      check("R10 last value kept B", rd_data_b, pat(202));
      commit();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 32; i++) model[i] = '0;
      t_fill();
      t_zero();
      t_bypass_one_port();
      t_disabled();
      t_unaffected();
      t_both();
      t_back_to_back();
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule